// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

This block resolves which of a set of interrupt lines a processor core should take next. Each line has a 4-bit priority value, and a smaller value is more urgent. A global group setting g, from 0 to 4, divides that value into two fields. The upper g bits form a preemption field and the remaining 4−g bits form a subpriority field. Software reaches the block through a small word-addressed register port. Through it software can:

- program the group setting and the per-line priorities,
- enable lines,
- set or clear pending bits,
- read back the active bits.

The block searches all lines combinationally for the best candidate that is both pending and enabled. It raises a request to the core only when nothing is active, or when that candidate's preemption field is strictly smaller than the most urgent preemption field among the active lines. Priority within equal preemption levels comes from the subpriority, and then from the line index. When the core acknowledges, the chosen line moves from pending to active. When the core signals completion for a line, that line's active bit clears. A rising edge on a line's input marks the line pending.

Top module: `grp_irq_arbiter`

## Requirements
- R1: After reset all enable, pending and active bits, the group setting and all priorities are zero, and `irq_req` is low.
- R2: Word 0 holds the group setting in bits 10:8, and reads return it there with all other bits zero. A written value above 4 is stored as 4.
- R3: Among lines that are both pending and enabled, the winner `irq_id` has the lowest preemption field, then the lowest subpriority, then the lowest index. This equals the lowest full 4-bit priority, with the lowest index winning ties.
- R4: When no line is active, `irq_req` is high whenever any line is pending and enabled. When some line is active, `irq_req` is high only if the winner's preemption field (priority >> (4−g)) is strictly below the smallest such field among active lines.
- R5: With group setting 0, `irq_req` stays low while any line is active.
- R6: A rising edge on `irq_in[k]` sets pending bit k even when line k is disabled. A disabled line is never reported as the winner.
- R7: The register map is as follows. Word 1 holds the enables and is read/write. Writing ones to word 2 sets pending bits. Writing ones to word 3 clears pending bits. Reads of words 2 and 3 return the pending bits. Word 4 returns the active bits, and writes to it are ignored. Words 8 + k/8 hold the priority of line k in bits 4·(k mod 8)+3 : 4·(k mod 8).
- R8: `ack` while `irq_req` is high clears the winner's pending bit and sets its active bit at the same clock edge. `ack` while `irq_req` is low has no effect.
- R9: `done` clears active bit `done_id` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_LINES | Interrupt inputs, rising edge marks pending |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| ack | input | 1 | Core takes the requested line |
| done | input | 1 | Core finished the line given by done_id |
| done_id | input | ID_W | Line whose handling completed |
| irq_req | output | 1 | Request to the core to take a line |
| irq_id | output | ID_W | Winning line index |

## Verification
The bench builds the arbiter with eight lines. With that size, every line's priority fits in a single priority word, so one register write sets a whole configuration. That makes a full sweep over group setting, active priority and pending priority practical, covering 5 × 16 × 16 combinations. The expected preemption decision in each case comes from shifting both priorities arithmetically. Pseudo-random mixes of priorities, enables and pending masks, including all-equal priorities that force index tie-breaks, check the winner search against a reference minimum computed in the bench.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;

    localparam int PRIO_W     = 4;
    localparam int MAX_GROUP  = 4;
    localparam int GROUP_LSB  = 8;
    localparam int PER_WORD   = 8;

    localparam int A_CTRL     = 0;
    localparam int A_ENABLE   = 1;
    localparam int A_PSET     = 2;
    localparam int A_PCLR     = 3;
    localparam int A_ACTIVE   = 4;
    localparam int A_PRIO     = 8;

    typedef logic [PRIO_W-1:0] prio_t;

    // Preemption field: upper g bits of the priority, right aligned.
    function automatic prio_t preempt_field(input prio_t p, input logic [2:0] g);
        return p >> (3'd4 - g);
    endfunction

endpackage

// File: rtl/grp_irq_winner.sv
module grp_irq_winner
    import grp_irq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ID_W      = $clog2(NUM_LINES)
) (
    input  prio_t [NUM_LINES-1:0] prio,
    input  logic  [NUM_LINES-1:0] cand,
    output logic                  valid,
    output logic  [ID_W-1:0]      id,
    output prio_t                 best
);

    // Ascending scan with strict compare keeps the lower index on ties;
    // the full 4-bit compare orders by preemption then subpriority.
    always_comb begin
        valid = 1'b0;
        id    = '0;
        best  = '1;
        for (int k = 0; k < NUM_LINES; k++) begin
            if (cand[k] && (!valid || prio[k] < best)) begin
                valid = 1'b1;
                id    = ID_W'(k);
                best  = prio[k];
            end
        end
    end

endmodule

// File: rtl/grp_irq_level.sv
module grp_irq_level
    import grp_irq_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  prio_t [NUM_LINES-1:0] prio,
    input  logic  [NUM_LINES-1:0] active,
    input  logic  [2:0]           group,
    output logic                  any_active,
    output prio_t                 level
);

    always_comb begin
        any_active = 1'b0;
        level      = '1;
        for (int k = 0; k < NUM_LINES; k++) begin
            if (active[k]) begin
                any_active = 1'b1;
                if (preempt_field(prio[k], group) < level)
                    level = preempt_field(prio[k], group);
            end
        end
    end

endmodule

// File: rtl/grp_irq_arbiter.sv
module grp_irq_arbiter
    import grp_irq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 5,
    parameter int ID_W      = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 ack,
    input  logic                 done,
    input  logic [ID_W-1:0]      done_id,
    output logic                 irq_req,
    output logic [ID_W-1:0]      irq_id
);

    localparam int PRIO_WORDS = (NUM_LINES + PER_WORD - 1) / PER_WORD;

    typedef struct packed {
        logic [2:0]                 group;
        logic [NUM_LINES-1:0]       en;
        logic [NUM_LINES-1:0]       pend;
        logic [NUM_LINES-1:0]       act;
        logic [NUM_LINES-1:0]       in_prev;
        prio_t [NUM_LINES-1:0]      prio;
    } state_t;

    state_t st_d, st_q;

    logic                 win_valid;
    logic [ID_W-1:0]      win_id;
    prio_t                win_prio;
    logic                 act_any;
    prio_t                act_level;
    prio_t                win_pre;
    logic [NUM_LINES-1:0] set_m, clr_m, ack_m, done_m, rise_m;

    grp_irq_winner #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_winner (
        .prio  (st_q.prio),
        .cand  (st_q.pend & st_q.en),
        .valid (win_valid),
        .id    (win_id),
        .best  (win_prio)
    );

    grp_irq_level #(.NUM_LINES(NUM_LINES)) u_level (
        .prio       (st_q.prio),
        .active     (st_q.act),
        .group      (st_q.group),
        .any_active (act_any),
        .level      (act_level)
    );

    assign win_pre = preempt_field(win_prio, st_q.group);
    assign irq_req = win_valid && (!act_any || win_pre < act_level);
    assign irq_id  = win_id;

    always_comb begin
        st_d    = st_q;
        set_m   = '0;
        clr_m   = '0;
        rise_m  = irq_in & ~st_q.in_prev;
        st_d.in_prev = irq_in;

        if (reg_wr) begin
            case (int'(reg_addr))
                A_CTRL:   st_d.group = (reg_wdata[GROUP_LSB+:3] > 3'(MAX_GROUP))
                                       ? 3'(MAX_GROUP) : reg_wdata[GROUP_LSB+:3];
                A_ENABLE: st_d.en = reg_wdata[NUM_LINES-1:0];
                A_PSET:   set_m   = reg_wdata[NUM_LINES-1:0];
                A_PCLR:   clr_m   = reg_wdata[NUM_LINES-1:0];
                default: begin
                    for (int k = 0; k < NUM_LINES; k++) begin
                        if (int'(reg_addr) == A_PRIO + k / PER_WORD)
                            st_d.prio[k] = reg_wdata[(k % PER_WORD)*PRIO_W +: PRIO_W];
                    end
                end
            endcase
        end

        for (int k = 0; k < NUM_LINES; k++) begin
            ack_m[k]  = ack && irq_req && (win_id == ID_W'(k));
            done_m[k] = done && (done_id == ID_W'(k));
        end

        // Clears first, then sets: an edge or set write in the same cycle wins.
        st_d.pend = (st_q.pend & ~clr_m & ~ack_m) | set_m | rise_m;
        st_d.act  = (st_q.act & ~done_m) | ack_m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (int'(reg_addr))
            A_CTRL:          reg_rdata[GROUP_LSB+:3]  = st_q.group;
            A_ENABLE:        reg_rdata[NUM_LINES-1:0] = st_q.en;
            A_PSET, A_PCLR:  reg_rdata[NUM_LINES-1:0] = st_q.pend;
            A_ACTIVE:        reg_rdata[NUM_LINES-1:0] = st_q.act;
            default: begin
                for (int k = 0; k < NUM_LINES; k++) begin
                    if (int'(reg_addr) == A_PRIO + k / PER_WORD)
                        reg_rdata[(k % PER_WORD)*PRIO_W +: PRIO_W] = st_q.prio[k];
                end
            end
        endcase
    end

    // Assertions
    a_r2_group_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.group <= 3'(MAX_GROUP));

    a_r5_no_preempt_group0: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.group == 3'd0 && |st_q.act) |-> !irq_req);

    a_r6_winner_enabled_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (st_q.en[irq_id] && st_q.pend[irq_id]));

    a_r8_ack_activates: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req) |=> st_q.act[$past(irq_id)]);

    a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(ack && irq_req && irq_id == done_id)) |=> !st_q.act[$past(done_id)]);

    a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(st_q.pend & st_q.en)) |-> !irq_req);

endmodule

// File: tb/grp_irq_arbiter_tb.sv
module grp_irq_arbiter_tb_top;

    localparam int N  = 8;
    localparam int AW = 5;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          ack = 1'b0;
    logic          done = 1'b0;
    logic [IW-1:0] done_id = '0;
    logic          irq_req;
    logic [IW-1:0] irq_id;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    grp_irq_arbiter #(.NUM_LINES(N), .ADDR_W(AW), .ID_W(IW)) dut_i (
        .clk, .rst_n, .irq_in, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .ack, .done, .done_id, .irq_req, .irq_id
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        reg_addr = AW'(a);
        #1;
        v = reg_rdata;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic pulse_done(input int id);
        @(negedge clk); done = 1'b1; done_id = IW'(id);
        @(negedge clk); done = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] seed;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a <= 8; a++) begin
            if (a > 4 && a < 8) continue;
            rd(a, v);
            check(v == 0, "R1 reset reg", v, 0);
        end
        check(irq_req == 1'b0, "R1 reset irq_req", irq_req, 0);

        // R2 group field readback and saturation
        for (int g = 0; g < 8; g++) begin
            wr(0, 32'(g) << 8 | 32'hFFFF_F8FF);
            rd(0, v);
            check(v == (32'(g > 4 ? 4 : g) << 8), "R2 group", v, (g > 4 ? 4 : g) << 8);
        end

        // R3 winner sweep, nothing active
        seed = 32'h1234_5678;
        for (int it = 0; it < 80; it++) begin
            logic [31:0] pw;
            logic [7:0]  en, pd, cand;
            int exp_id, best;
            seed = seed * 32'd1103515245 + 32'd12345; pw = seed;
            if (it % 4 == 0) pw = {8{seed[19:16]}};
            seed = seed * 32'd1103515245 + 32'd12345; en = seed[23:16];
            seed = seed * 32'd1103515245 + 32'd12345; pd = seed[23:16];
            if (it % 5 == 0) en = 8'hFF;
            wr(8, pw); wr(1, {24'b0, en}); wr(2, {24'b0, pd});
            cand = en & pd; exp_id = -1; best = 16;
            for (int k = 0; k < N; k++)
                if (cand[k] && int'(pw[4*k +: 4]) < best) begin
                    best = int'(pw[4*k +: 4]); exp_id = k;
                end
            check(irq_req == (exp_id >= 0), "R3 R4 req idle", irq_req, exp_id >= 0);
            if (exp_id >= 0)
                check(int'(irq_id) == exp_id, "R3 winner id", irq_id, exp_id);
            wr(3, 32'hFF);
        end

        // R4 / R5 preemption sweep: line 0 active with prio a, line 1 pending with prio p
        wr(1, 32'h3);
        for (int g = 0; g <= 4; g++) begin
            wr(0, 32'(g) << 8);
            for (int a = 0; a < 16; a++) begin
                for (int p = 0; p < 16; p++) begin
                    bit exp;
                    wr(8, 32'((p << 4) | a));
                    wr(2, 32'h1);
                    pulse_ack();
                    rd(4, v);
                    check(v == 32'h1, "R8 ack active", v, 1);
                    wr(2, 32'h2);
                    exp = (g != 0) && ((p >> (4 - g)) < (a >> (4 - g)));
                    if (g == 0) check(irq_req == 1'b0, "R5 group0 no preempt", irq_req, 0);
                    else        check(irq_req == exp, "R4 preempt", irq_req, exp);
                    if (exp) check(irq_id == 3'd1, "R4 preempt id", irq_id, 1);
                    pulse_done(0);
                    wr(3, 32'h2);
                end
            end
        end

        // R6 edge sets pending on disabled line; disabled never selected
        wr(0, 32'h400);
        wr(1, 32'h0);
        @(negedge clk); irq_in[3] = 1'b1;
        @(negedge clk); irq_in[3] = 1'b0;
        rd(2, v);
        check(v == 32'h8, "R6 edge pending", v, 8);
        check(irq_req == 1'b0, "R6 disabled not selected", irq_req, 0);
        wr(1, 32'h8);
        check(irq_req && irq_id == 3'd3, "R6 enabled selected", irq_id, 3);

        // R8 ack moves pending to active
        pulse_ack();
        rd(2, v); check(v == 0, "R8 pending cleared", v, 0);
        rd(4, v); check(v == 32'h8, "R8 active set", v, 8);
        pulse_ack();
        rd(4, v); check(v == 32'h8, "R8 ack ignored", v, 8);
        rd(2, v); check(v == 0, "R8 ack ignored pend", v, 0);

        // R9 done clears
        pulse_done(3);
        rd(4, v); check(v == 0, "R9 done clears", v, 0);

        // R7 register map
        wr(8, 32'h7654_3210);
        rd(8, v); check(v == 32'h7654_3210, "R7 prio word", v, 32'h7654_3210);
        wr(1, 32'h0);
        wr(2, 32'h5A);
        rd(2, v); check(v == 32'h5A, "R7 pend set", v, 32'h5A);
        wr(3, 32'h0A);
        rd(3, v); check(v == 32'h50, "R7 pend clear", v, 32'h50);
        wr(4, 32'hFF);
        rd(4, v); check(v == 0, "R7 active read-only", v, 0);
        rd(1, v); check(v == 0, "R7 enable readback", v, 0);

        finish_run();
    end

endmodule